// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

The block is a down-counting timer that produces a regular timeout for step-pulse or tick generation. Software programs it through a simple single-cycle write port. Through that port it sets enable, periodic or one-shot operation, the update policy, an 8-bit prescale, a 32-bit reload value, an interrupt mask and a flag clear. The block drives the live count, a sticky timeout flag and a masked interrupt line.

Reload and prescale writes first land in shadow registers. In timeout-update mode the period in progress always completes with the old values, and the new values take over at the next timeout. In immediate mode the counter restarts from the written value right away. A write that coincides with a timeout is never lost or partly applied. Turning the timer off freezes the count. Turning it on again starts a fresh period from the most recent values. A plain off/on sequence is therefore a safe way to change the period at any time.

Top module: `tick_timer`

## Requirements
- R1: Write address 2 sets the reload value L. While running in periodic mode, the count steps down from L to 0 and then reloads. A timeout occurs only on the tick taken while the count is 0, so each period is L+1 ticks.
- R2: Write address 1 sets the prescale P, in the range 0 to 255, from bits [7:0]. One tick lasts P+1 clocks. The first timeout comes (P+1)×(L+1) clocks after the enabling write clock, and every later periodic timeout follows (P+1)×(L+1) clocks after the one before.
- R3: Timeout-update mode is control bit 2 = 0. In this mode, a reload value written while running does not alter the period in progress; it applies from the next timeout onward.
- R4: Immediate mode is control bit 2 = 1. In this mode, a reload value written while running restarts the count from that value, and the next timeout comes (P+1)×(L+1) clocks after the write clock.
- R5: A prescale write follows the same update mode as a reload write: in timeout-update mode the period in progress keeps the old prescale.
- R6: Writing 0 to control bit 0 (address 0) stops the timer. The count then holds its value and no timeout occurs.
- R7: Writing control bit 0 from 0 to 1 starts a fresh period from the latest reload and prescale values. The count shows L one clock after the write, and no old-period remainder is kept.
- R8: One-shot mode is control bit 1 = 1. In this mode, the timer stops at count 0 after its first timeout and raises no further timeout.
- R9: Each timeout sets a sticky flag. The flag is cleared by writing bit 0 = 1 to address 4. The interrupt output equals the flag ANDed with the mask, which is bit 0 of address 3, so unmasking a set flag raises the interrupt at once.
- R10: A reload write in the same clock as a timeout is the value reloaded.
- R11: A flag clear in the same clock as a timeout leaves the flag set.
- R12: After reset the timer is stopped, in periodic and timeout-update mode, with prescale 0, reload and count 0xFFFFFFFF, the flag clear and the interrupt masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 prescale, 2 reload, 3 mask, 4 clear |
| wr_data | input | 32 | Write data |
| count | output | 32 | Current counter value |
| tmo_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest cases to reach from the ports are two same-clock collisions: a reload write on exactly the clock of a timeout, and a flag clear on exactly the clock of a timeout. The bench counts clocks from the enabling write. From that count and the (P+1)×(L+1) rule it computes the timeout clock in advance, then issues the write so that its clock edge lands on that timeout edge. It checks the count and the flag right after that edge and measures the period that follows.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] TT_A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] TT_A_PRE   = 3'd1;
  localparam logic [ADDR_W-1:0] TT_A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] TT_A_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] TT_A_CLEAR = 3'd4;

  // control word bit positions
  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_ONCE = 1;
  localparam int unsigned CTL_IMM  = 2;

  typedef struct packed {
    logic imm;
    logic once;
    logic run;
  } tt_ctrl_t;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output tt_ctrl_t          ctrl_q,
  output logic              mask_q,
  output logic [CNT_W-1:0]  sh_load_q,
  output logic [CNT_W-1:0]  load_nx,
  output logic [PRE_W-1:0]  pre_nx,
  output logic              start,
  output logic              ld_wr,
  output logic              pre_wr,
  output logic              clr_req
);

  logic [PRE_W-1:0] sh_pre_q;
  logic             ctl_wr, mask_wr;
  tt_ctrl_t         ctrl_d;
  logic             mask_d;
  logic [CNT_W-1:0] sh_load_d;
  logic [PRE_W-1:0] sh_pre_d;

  // write decode
  always_comb begin
    ctl_wr  = wr_en && (wr_addr == TT_A_CTRL);
    pre_wr  = wr_en && (wr_addr == TT_A_PRE);
    ld_wr   = wr_en && (wr_addr == TT_A_LOAD);
    mask_wr = wr_en && (wr_addr == TT_A_MASK);
    clr_req = wr_en && (wr_addr == TT_A_CLEAR) && wr_data[0];
    start   = ctl_wr && wr_data[CTL_RUN] && !ctrl_q.run;
  end

  // latest programmed values, including a write in this very clock
  always_comb begin
    load_nx = ld_wr  ? wr_data : sh_load_q;
    pre_nx  = pre_wr ? wr_data[PRE_W-1:0] : sh_pre_q;
  end

  // next state
  always_comb begin
    ctrl_d    = ctrl_q;
    mask_d    = mask_q;
    sh_load_d = load_nx;
    sh_pre_d  = pre_nx;
    if (ctl_wr) begin
      ctrl_d.run  = wr_data[CTL_RUN];
      ctrl_d.once = wr_data[CTL_ONCE];
      ctrl_d.imm  = wr_data[CTL_IMM];
    end
    if (mask_wr) mask_d = wr_data[0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      mask_q    <= 1'b0;
      sh_load_q <= '1;
      sh_pre_q  <= '0;
    end else if (wr_en) begin
      ctrl_q    <= ctrl_d;
      mask_q    <= mask_d;
      sh_load_q <= sh_load_d;
      sh_pre_q  <= sh_pre_d;
    end
  end

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             once,
  input  logic             imm,
  input  logic             start,
  input  logic             ld_wr,
  input  logic             pre_wr,
  input  logic [CNT_W-1:0] load_nx,
  input  logic [PRE_W-1:0] pre_nx,
  output logic [CNT_W-1:0] count,
  output logic             tmo,
  output logic             running
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [PRE_W-1:0] act_pre_q, act_pre_d;
  logic             done_q, done_d;
  logic             tick, upd;

  always_comb begin
    running = en && !done_q;
    tick    = running && (pcnt_q == act_pre_q);
    tmo     = tick && (cnt_q == '0);
    upd     = start || running;
  end

  // next state
  always_comb begin
    cnt_d     = cnt_q;
    pcnt_d    = pcnt_q;
    act_pre_d = act_pre_q;
    done_d    = done_q;
    if (start) begin
      cnt_d     = load_nx;
      pcnt_d    = '0;
      act_pre_d = pre_nx;
      done_d    = 1'b0;
    end else if (running) begin
      if (tmo) begin
        pcnt_d    = '0;
        act_pre_d = pre_nx;
        if (once) done_d = 1'b1;
        else      cnt_d  = load_nx;
      end else begin
        if (tick) begin
          pcnt_d = '0;
          cnt_d  = cnt_q - CNT_ONE;
        end else begin
          pcnt_d = pcnt_q + PRE_ONE;
        end
        if (imm) begin
          if (ld_wr) begin
            cnt_d  = load_nx;
            pcnt_d = '0;
          end
          if (pre_wr) begin
            act_pre_d = pre_nx;
            pcnt_d    = '0;
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      pcnt_q    <= '0;
      act_pre_q <= '0;
      done_q    <= 1'b0;
    end else if (upd) begin
      cnt_q     <= cnt_d;
      pcnt_q    <= pcnt_d;
      act_pre_q <= act_pre_d;
      done_q    <= done_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo,
  input  logic clr_req,
  input  logic mask,
  output logic flag,
  output logic irq
);

  logic flag_d, flag_en;

  always_comb begin
    flag_en = tmo || clr_req;
    flag_d  = tmo ? 1'b1 : 1'b0;   // a timeout beats a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end

  assign irq = flag && mask;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             tmo_flag,
  output logic             irq
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  tt_ctrl_t         ctrl_q;
  logic             mask_q;
  logic [CNT_W-1:0] sh_load_w, load_nx_w;
  logic [PRE_W-1:0] pre_nx_w;
  logic             start_w, ld_wr_w, pre_wr_w, clr_w;
  logic             tmo_w, run_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tick_timer_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask_q),
    .sh_load_q (sh_load_w),
    .load_nx   (load_nx_w),
    .pre_nx    (pre_nx_w),
    .start     (start_w),
    .ld_wr     (ld_wr_w),
    .pre_wr    (pre_wr_w),
    .clr_req   (clr_w)
  );

  tick_timer_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (ctrl_q.run),
    .once    (ctrl_q.once),
    .imm     (ctrl_q.imm),
    .start   (start_w),
    .ld_wr   (ld_wr_w),
    .pre_wr  (pre_wr_w),
    .load_nx (load_nx_w),
    .pre_nx  (pre_nx_w),
    .count   (count),
    .tmo     (tmo_w),
    .running (run_w)
  );

  tick_timer_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tmo     (tmo_w),
    .clr_req (clr_w),
    .mask    (mask_q),
    .flag    (tmo_flag),
    .irq     (irq)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] sh_load,
  input logic             tmo,
  input logic             run_en,
  input logic             once,
  input logic             running,
  input logic             start,
  input logic             tmo_flag,
  input logic             irq
);

  logic ctl_wr;
  assign ctl_wr = wr_en && (wr_addr == 3'd0);

  AST_TMO_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> (count == '0)); // R1

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !once) |=> (count == sh_load)); // R10

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !ctl_wr) |=> $stable(count)); // R6

  AST_NO_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tmo); // R6

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !running) |=> $stable(count)); // R8

  AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == sh_load)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> tmo_flag); // R11

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tmo_flag); // R9

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .count    (count),
  .sh_load  (sh_load_w),
  .tmo      (tmo_w),
  .run_en   (ctrl_q.run),
  .once     (ctrl_q.once),
  .running  (run_w),
  .start    (start_w),
  .tmo_flag (tmo_flag),
  .irq      (irq)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

  localparam logic [2:0] A_CTRL = 3'd0, A_PRE = 3'd1, A_LOAD = 3'd2,
                         A_MASK = 3'd3, A_CLR = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] count;
  logic        tmo_flag, irq;

  int cyc = 0;
  int last_wr = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .tmo_flag(tmo_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // write takes effect on the next rising edge; returns at the negedge after it
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_wr = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_tmo(output int e);
    int n = 0;
    while (!tmo_flag && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!tmo_flag) begin
      n_chk++; n_fail++;
      $display("FAIL timeout-wait actual=0 expected=1 (cycle %0d)", cyc);
    end
    e = cyc;
  endtask

  task automatic stop_all();
    wr(A_CTRL, 32'd0);
    wr(A_CLR, 32'd1);
  endtask

  task automatic t_reset();
    chk(count == 32'hFFFF_FFFF, "R12 count", count, 32'hFFFF_FFFF);
    chk(tmo_flag == 1'b0, "R12 flag", tmo_flag, 0);
    chk(irq == 1'b0, "R12 irq", irq, 0);
    idle(20);
    chk(count == 32'hFFFF_FFFF && !tmo_flag, "R12 stopped", count, 32'hFFFF_FFFF);
  endtask

  task automatic t_basic();
    int e0, t1, t2;
    wr(A_LOAD, 32'd4); wr(A_PRE, 32'd0);
    wr(A_CTRL, 32'd1); e0 = last_wr;
    chk(count == 32'd4, "R7 count after start", count, 4);
    wait_tmo(t1);
    chk(count == 32'd4, "R1 reload after timeout", count, 4);
    chk(t1 - e0 == 5, "R1 first period", t1 - e0, 5);
    wr(A_CLR, 32'd1);
    wait_tmo(t2);
    chk(t2 - t1 == 5, "R1 second period", t2 - t1, 5);
    stop_all();
  endtask

  task automatic t_prescale();
    int e0, t1, t2;
    wr(A_LOAD, 32'd3); wr(A_PRE, 32'd2);
    wr(A_CTRL, 32'd1); e0 = last_wr;
    wait_tmo(t1);
    chk(t1 - e0 == 12, "R2 first period", t1 - e0, 12);
    wr(A_CLR, 32'd1);
    wait_tmo(t2);
    chk(t2 - t1 == 12, "R2 periodic", t2 - t1, 12);
    stop_all();
    wr(A_PRE, 32'd0);
  endtask

  task automatic t_shadow_load();
    int e0, t1, t2, t3;
    wr(A_LOAD, 32'd9);
    wr(A_CTRL, 32'd1); e0 = last_wr;
    wait_tmo(t1);
    wr(A_CLR, 32'd1);
    wr(A_LOAD, 32'd3);
    wait_tmo(t2);
    chk(t2 - t1 == 10, "R3 old period kept", t2 - t1, 10);
    wr(A_CLR, 32'd1);
    wait_tmo(t3);
    chk(t3 - t2 == 4, "R3 new period", t3 - t2, 4);
    stop_all();
  endtask

  task automatic t_immediate();
    int e0, w, t1, t2;
    wr(A_LOAD, 32'd9);
    wr(A_CTRL, 32'd5); e0 = last_wr;
    idle(2);
    wr(A_LOAD, 32'd2); w = last_wr;
    chk(count == 32'd2, "R4 count restarted", count, 2);
    wait_tmo(t1);
    chk(t1 - w == 3, "R4 immediate period", t1 - w, 3);
    wr(A_CLR, 32'd1);
    wait_tmo(t2);
    chk(t2 - t1 == 3, "R4 following period", t2 - t1, 3);
    stop_all();
  endtask

  task automatic t_shadow_pre();
    int e0, t1, t2, t3;
    wr(A_LOAD, 32'd3); wr(A_PRE, 32'd0);
    wr(A_CTRL, 32'd1); e0 = last_wr;
    wait_tmo(t1);
    wr(A_CLR, 32'd1);
    wr(A_PRE, 32'd1);
    wait_tmo(t2);
    chk(t2 - t1 == 4, "R5 old prescale kept", t2 - t1, 4);
    wr(A_CLR, 32'd1);
    wait_tmo(t3);
    chk(t3 - t2 == 8, "R5 new prescale", t3 - t2, 8);
    stop_all();
    wr(A_PRE, 32'd0);
  endtask

  task automatic t_disable();
    int e1, t;
    logic [31:0] c0;
    wr(A_LOAD, 32'd20);
    wr(A_CTRL, 32'd1);
    idle(3);
    wr(A_CTRL, 32'd0);
    c0 = count;
    idle(30);
    chk(count == c0, "R6 count frozen", count, c0);
    chk(tmo_flag == 1'b0, "R6 no timeout", tmo_flag, 0);
    wr(A_LOAD, 32'd6);
    wr(A_CTRL, 32'd1); e1 = last_wr;
    chk(count == 32'd6, "R7 fresh count", count, 6);
    wait_tmo(t);
    chk(t - e1 == 7, "R7 fresh period", t - e1, 7);
    stop_all();
  endtask

  task automatic t_oneshot_irq();
    int e0, t;
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, 32'd3); e0 = last_wr;
    wait_tmo(t);
    chk(t - e0 == 6, "R8 one-shot period", t - e0, 6);
    chk(irq == 1'b0, "R9 masked irq", irq, 0);
    wr(A_MASK, 32'd1);
    chk(irq == 1'b1, "R9 unmask raises irq", irq, 1);
    wr(A_CLR, 32'd1);
    chk(tmo_flag == 1'b0 && irq == 1'b0, "R9 clear drops irq", irq, 0);
    idle(40);
    chk(tmo_flag == 1'b0, "R8 no second timeout", tmo_flag, 0);
    chk(count == 32'd0, "R8 held at zero", count, 0);
    wr(A_MASK, 32'd0);
    stop_all();
  endtask

  task automatic t_write_collide();
    int e0, t1, t2, t3;
    wr(A_LOAD, 32'd7);
    wr(A_CTRL, 32'd1); e0 = last_wr;
    wait_tmo(t1);
    wr(A_CLR, 32'd1);
    wait_until(t1 + 7);
    wr(A_LOAD, 32'd2);                 // edge t1+8 is a timeout edge
    wait_tmo(t2);
    chk(t2 == t1 + 8, "R10 collide timeout edge", t2, t1 + 8);
    chk(count == 32'd2, "R10 written value reloaded", count, 2);
    wr(A_CLR, 32'd1);
    wait_tmo(t3);
    chk(t3 - t2 == 3, "R10 new period", t3 - t2, 3);
    stop_all();
  endtask

  task automatic t_clear_collide();
    int e0, t1;
    wr(A_LOAD, 32'd4);
    wr(A_CTRL, 32'd1); e0 = last_wr;
    wait_tmo(t1);
    wr(A_CLR, 32'd1);
    chk(tmo_flag == 1'b0, "R9 plain clear", tmo_flag, 0);
    wait_until(t1 + 4);
    wr(A_CLR, 32'd1);                  // edge t1+5 is a timeout edge
    chk(tmo_flag == 1'b1, "R11 set wins over clear", tmo_flag, 1);
    stop_all();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_prescale();
    t_shadow_load();
    t_immediate();
    t_shadow_pre();
    t_disable();
    t_oneshot_irq();
    t_write_collide();
    t_clear_collide();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    finish_run();
  end

endmodule